// File: doc/BRIEF.md
# Processor Exception and Interrupt Controller

This block decides when a simple 32-bit core leaves its normal instruction stream for a trap handler, and when it comes back. It keeps three control registers: a status word with the global enable, the exception-level flag, the user-mode flag and an eight-bit line mask; a cause word with the captured request lines, the last trap code and the delay-slot flag; and a saved return address. Software reads and writes these registers through a register-move port that is selected by register number.

Each cycle the pipeline presents its current PC, a flag saying whether that instruction sits in a branch delay slot, and an optional synchronous exception with a five-bit code. Eight external request lines are captured into the cause word. When an exception arrives, or when an enabled and unmasked line is pending while no trap is in progress, the block raises a redirect in the same cycle toward the fixed handler entry. On the following edge it records the trap and blocks further interrupts. A return command redirects the core to the saved address and lifts that block.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset the status, cause and return-address registers read as zero and no redirect is requested.
- R2: Register 12 (status) keeps only bit 0 (global enable), bit 1 (exception level), bit 4 (user mode) and bits 15..8 (line mask) from a software write. All other bits read as zero.
- R3: Register 13 (cause) ignores software writes. Its bits 15..8 show the request lines as they were sampled on the previous clock edge.
- R4: An interrupt is requested when the global enable is 1, the exception level is 0 and at least one captured line has its mask bit set. In that cycle redirect_valid is 1 and redirect_pc is 0x80000180.
- R5: While the global enable is 0, no pending line causes a redirect.
- R6: A pending line whose mask bit is 0 causes no redirect.
- R7: Taking a trap sets the exception level on the next edge, and this blocks further interrupts until a return.
- R8: Cause bits 6..2 hold the code of the last trap taken: the exception code for an exception, and 0 for an interrupt.
- R9: On a trap, cause bit 31 copies the delay-slot flag. Register 14 receives the current PC minus 4 when the flag is set, and the current PC otherwise.
- R10: An exception request in the same cycle as a pending interrupt wins, and its code is recorded.
- R11: A return command redirects to the saved address and clears the exception level on the next edge. A trap in the same cycle takes precedence over the return.
- R12: Register 14 can be written by software and read back. A later return command uses the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | External interrupt request lines |
| cur_pc | input | 32 | PC of the instruction in the trap stage |
| in_delay_slot | input | 1 | That instruction is in a branch delay slot |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Code of the requested exception |
| eret_req | input | 1 | Return-from-trap command |
| reg_wr_en | input | 1 | Register-move write strobe |
| reg_wr_sel | input | 5 | Register number written |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 5 | Register number read |
| reg_rd_data | output | 32 | Read data (combinational) |
| redirect_valid | output | 1 | Core must fetch from redirect_pc |
| redirect_pc | output | 32 | Handler entry or return address |

## Verification
The interrupt decision is exercised with a single unmasked line, an all-lines burst while the enable is off, a line outside the mask, and a line that is still pending after entry. Each of these isolates one term of the request condition: the enable, the mask and the exception level. Exceptions are driven with and without the delay-slot flag, which separates the two saved-address forms and the cause bit-31 behaviour. Two cases resolve same-cycle collisions: an exception against a pending line, and an exception against a return. The recorded code and the redirect target show which event won.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int XLEN   = 32;
  localparam int IRQ_N  = 8;
  localparam int CODE_W = 5;
  localparam int MASK_LSB = 8;
  localparam int CODE_LSB = 2;
  localparam int BD_BIT   = XLEN - 1;
  localparam logic [CODE_W-1:0] CODE_INTERRUPT = '0;

  typedef struct packed {
    logic [IRQ_N-1:0] mask;
    logic             user;
    logic             exl;
    logic             ie;
  } status_t;

  // Address saved on trap entry: re-run the branch when in a delay slot.
  function automatic logic [XLEN-1:0] f_saved_pc(input logic [XLEN-1:0] pc,
                                                 input logic slot);
    return slot ? (pc - XLEN'(4)) : pc;
  endfunction

  // Interrupt request condition from status and captured lines.
  function automatic logic f_irq_wanted(input status_t st,
                                        input logic [IRQ_N-1:0] pend);
    return st.ie && !st.exl && |(pend & st.mask);
  endfunction

  function automatic logic [XLEN-1:0] f_status_word(input status_t st);
    logic [XLEN-1:0] w;
    w = '0;
    w[MASK_LSB +: IRQ_N] = st.mask;
    w[4] = st.user;
    w[1] = st.exl;
    w[0] = st.ie;
    return w;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IRQ_N-1:0] wr_mask,
  input  logic             wr_user,
  input  logic             wr_exl,
  input  logic             wr_ie,
  input  logic             enter,
  input  logic             leave,
  output status_t          status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
    end else if (enter) begin
      status.exl <= 1'b1;
    end else if (leave) begin
      status.exl <= 1'b0;
    end else if (wr_en) begin
      status.mask <= wr_mask;
      status.user <= wr_user;
      status.exl  <= wr_exl;
      status.ie   <= wr_ie;
    end
  end

  assert_exl_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> status.exl);
  assert_exl_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && !enter) |=> !status.exl);
endmodule

// File: rtl/irq_cause_epc.sv
module irq_cause_epc
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irq_lines,
  input  logic              enter,
  input  logic [CODE_W-1:0] enter_code,
  input  logic              slot_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              epc_wr_en,
  input  logic [XLEN-1:0]   epc_wr_data,
  output logic [IRQ_N-1:0]  pend,
  output logic [XLEN-1:0]   cause_word,
  output logic [XLEN-1:0]   epc
);
  logic [CODE_W-1:0] code_q;
  logic              bd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= irq_lines;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
      epc    <= '0;
    end else if (enter) begin
      code_q <= enter_code;
      bd_q   <= slot_in;
      epc    <= f_saved_pc(pc_in, slot_in);
    end else if (epc_wr_en) begin
      epc <= epc_wr_data;
    end
  end

  always_comb begin
    cause_word = '0;
    cause_word[BD_BIT] = bd_q;
    cause_word[MASK_LSB +: IRQ_N] = pend;
    cause_word[CODE_LSB +: CODE_W] = code_q;
  end

  assert_epc_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && slot_in) |=> (epc + XLEN'(4) == $past(pc_in)));
  assert_epc_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !slot_in) |=> (epc == $past(pc_in)));
  assert_code_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (cause_word[CODE_LSB +: CODE_W] == $past(enter_code)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctl_pkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  status_t           status,
  input  logic [IRQ_N-1:0]  pend,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              eret_req,
  input  logic [XLEN-1:0]   epc,
  output logic              enter,
  output logic [CODE_W-1:0] enter_code,
  output logic              int_take,
  output logic              eret_fire,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc
);
  logic [IRQ_N-1:0] line_hit;
  logic             irq_wanted;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    assign line_hit[i] = pend[i] & status.mask[i];
  end

  assign irq_wanted = f_irq_wanted(status, pend);
  assign int_take   = irq_wanted && !exc_req;
  assign enter      = exc_req || irq_wanted;
  assign enter_code = exc_req ? exc_code : CODE_INTERRUPT;
  assign eret_fire  = eret_req && !enter;

  assign redirect_valid = enter || eret_fire;
  assign redirect_pc    = enter ? HANDLER_VEC : epc;

  assert_exc_over_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !int_take);
  assert_irq_has_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> (line_hit != '0));
  assert_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> (redirect_pc == HANDLER_VEC));
  assert_entry_beats_eret_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && eret_req) |-> !eret_fire);
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
  import irq_ctl_pkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180,
  parameter int              SEL_W       = 5,
  parameter logic [SEL_W-1:0] SEL_STATUS = 5'd12,
  parameter logic [SEL_W-1:0] SEL_CAUSE  = 5'd13,
  parameter logic [SEL_W-1:0] SEL_EPC    = 5'd14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irq_lines,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_delay_slot,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              eret_req,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_wr_sel,
  input  logic [XLEN-1:0]   reg_wr_data,
  input  logic [SEL_W-1:0]  reg_rd_sel,
  output logic [XLEN-1:0]   reg_rd_data,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc
);
  status_t           status;
  logic [IRQ_N-1:0]  pend;
  logic [XLEN-1:0]   cause_word;
  logic [XLEN-1:0]   epc;
  logic              enter;
  logic [CODE_W-1:0] enter_code;
  logic              int_take;
  logic              eret_fire;
  logic              st_wr;
  logic              epc_wr;

  assign st_wr  = reg_wr_en && (reg_wr_sel == SEL_STATUS);
  assign epc_wr = reg_wr_en && (reg_wr_sel == SEL_EPC);

  irq_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_wr),
    .wr_mask (reg_wr_data[MASK_LSB +: IRQ_N]),
    .wr_user (reg_wr_data[4]),
    .wr_exl  (reg_wr_data[1]),
    .wr_ie   (reg_wr_data[0]),
    .enter   (enter),
    .leave   (eret_fire),
    .status  (status)
  );

  irq_cause_epc u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .enter       (enter),
    .enter_code  (enter_code),
    .slot_in     (in_delay_slot),
    .pc_in       (cur_pc),
    .epc_wr_en   (epc_wr),
    .epc_wr_data (reg_wr_data),
    .pend        (pend),
    .cause_word  (cause_word),
    .epc         (epc)
  );

  irq_arbiter #(.HANDLER_VEC(HANDLER_VEC)) u_arb (
    .clk            (clk),
    .rst_n          (rst_n),
    .status         (status),
    .pend           (pend),
    .exc_req        (exc_req),
    .exc_code       (exc_code),
    .eret_req       (eret_req),
    .epc            (epc),
    .enter          (enter),
    .enter_code     (enter_code),
    .int_take       (int_take),
    .eret_fire      (eret_fire),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  always_comb begin
    if (reg_rd_sel == SEL_STATUS)     reg_rd_data = f_status_word(status);
    else if (reg_rd_sel == SEL_CAUSE) reg_rd_data = cause_word;
    else if (reg_rd_sel == SEL_EPC)   reg_rd_data = epc;
    else                              reg_rd_data = '0;
  end

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!status.ie && !exc_req && !eret_req) |-> !redirect_valid);
  assert_nested_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status.exl && !exc_req && !eret_req) |-> !redirect_valid);
  assert_irq_code_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |=> (cause_word[CODE_LSB +: CODE_W] == CODE_INTERRUPT));
  assert_pend_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend == $past(irq_lines)));
endmodule

// File: tb/irq_ctl_unit_test.sv
module irq_ctl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_lines = '0;
  logic [31:0] cur_pc = '0;
  logic        in_delay_slot = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        eret_req = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [4:0]  reg_rd_sel = '0;
  logic [31:0] reg_rd_data;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int n_checks = 0;
  int n_err = 0;
  localparam logic [31:0] VEC = 32'h8000_0180;

  always #5 clk = ~clk;

  irq_ctl_unit uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cur_pc(cur_pc),
    .in_delay_slot(in_delay_slot), .exc_req(exc_req), .exc_code(exc_code),
    .eret_req(eret_req), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel),
    .reg_rd_data(reg_rd_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] s, output logic [31:0] v);
    reg_rd_sel = s;
    #1;
    v = reg_rd_data;
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = s; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // One clean return to leave the trap state.
  task automatic do_return();
    @(negedge clk);
    eret_req = 1'b1;
    @(negedge clk);
    eret_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd(5'd12, v); chk("R1", "status after reset", v, 32'h0);
    rd(5'd13, v); chk("R1", "cause after reset", v, 32'h0);
    rd(5'd14, v); chk("R1", "epc after reset", v, 32'h0);
    chk("R1", "no redirect after reset", {31'b0, redirect_valid}, 32'h0);
  endtask

  task automatic t_status_rw();
    logic [31:0] v;
    wr(5'd12, 32'hFFFF_FFFE);
    #1; rd(5'd12, v); chk("R2", "status write mask", v, 32'h0000_FF12);
    wr(5'd12, 32'h0000_0000);
    #1; rd(5'd12, v); chk("R2", "status cleared", v, 32'h0);
  endtask

  task automatic t_cause_readonly();
    logic [31:0] v;
    wr(5'd13, 32'hFFFF_FFFF);
    #1; rd(5'd13, v); chk("R3", "cause ignores write", v, 32'h0);
    @(negedge clk); irq_lines = 8'hA5;
    #1; rd(5'd13, v); chk("R3", "pending not before edge", v, 32'h0);
    @(negedge clk);
    #1; rd(5'd13, v); chk("R3", "pending bits after edge", v, 32'h0000_A500);
    chk("R5", "enable off blocks burst", {31'b0, redirect_valid}, 32'h0);
    @(negedge clk); irq_lines = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_masked();
    wr(5'd12, 32'h0000_0101);
    @(negedge clk); irq_lines = 8'h80;
    @(negedge clk);
    #1; chk("R6", "masked line ignored", {31'b0, redirect_valid}, 32'h0);
    irq_lines = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    wr(5'd12, 32'h0000_FF00);
    @(negedge clk); irq_lines = 8'hFF;
    @(negedge clk);
    #1; chk("R5", "no redirect while disabled", {31'b0, redirect_valid}, 32'h0);
    @(negedge clk);
    #1; chk("R5", "still none while disabled", {31'b0, redirect_valid}, 32'h0);
    reg_wr_en = 1'b1; reg_wr_sel = 5'd12; reg_wr_data = 32'h0000_FF01;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1; chk("R4", "enable releases request", {31'b0, redirect_valid}, 32'h1);
    irq_lines = 8'h00;
    @(negedge clk);
    do_return();
  endtask

  task automatic t_irq_take();
    logic [31:0] v;
    wr(5'd12, 32'h0000_FF01);
    @(negedge clk);
    cur_pc = 32'h0040_0020; in_delay_slot = 1'b0; irq_lines = 8'h10;
    @(negedge clk);
    #1; chk("R4", "interrupt redirect", {31'b0, redirect_valid}, 32'h1);
    chk("R4", "handler vector", redirect_pc, VEC);
    @(negedge clk);
    irq_lines = 8'h00;
    #1; chk("R7", "nested interrupt blocked", {31'b0, redirect_valid}, 32'h0);
    rd(5'd12, v); chk("R7", "exception level set", v, 32'h0000_FF03);
    rd(5'd13, v); chk("R8", "interrupt code zero", v, 32'h0000_1000);
    rd(5'd14, v); chk("R9", "saved pc no slot", v, 32'h0040_0020);
  endtask

  task automatic t_eret();
    logic [31:0] v;
    @(negedge clk); eret_req = 1'b1;
    #1; chk("R11", "return redirect", {31'b0, redirect_valid}, 32'h1);
    chk("R11", "return target", redirect_pc, 32'h0040_0020);
    @(negedge clk); eret_req = 1'b0;
    #1; rd(5'd12, v); chk("R11", "exception level cleared", v, 32'h0000_FF01);
    chk("R11", "quiet after return", {31'b0, redirect_valid}, 32'h0);
  endtask

  task automatic t_exception_slot();
    logic [31:0] v;
    @(negedge clk);
    cur_pc = 32'h0040_0100; in_delay_slot = 1'b1; exc_req = 1'b1; exc_code = 5'd8;
    #1; chk("R4", "exception redirect vector", redirect_pc, VEC);
    @(negedge clk);
    exc_req = 1'b0; in_delay_slot = 1'b0;
    #1; rd(5'd13, v); chk("R9", "cause slot flag and code", v, 32'h8000_0020);
    rd(5'd14, v); chk("R9", "saved pc minus four", v, 32'h0040_00FC);
    do_return();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk); irq_lines = 8'h01;
    @(negedge clk);
    cur_pc = 32'h0000_0500; exc_req = 1'b1; exc_code = 5'd4;
    #1; chk("R10", "redirect on collision", {31'b0, redirect_valid}, 32'h1);
    @(negedge clk);
    exc_req = 1'b0;
    #1; rd(5'd13, v); chk("R10", "exception code wins", v, 32'h0000_0110);
    irq_lines = 8'h00;
    @(negedge clk);
    cur_pc = 32'h0000_0600; exc_req = 1'b1; exc_code = 5'd12; eret_req = 1'b1;
    #1; chk("R11", "trap beats return target", redirect_pc, VEC);
    @(negedge clk);
    exc_req = 1'b0; eret_req = 1'b0;
    #1; rd(5'd12, v); chk("R11", "level kept after trap vs return", v, 32'h0000_FF03);
    rd(5'd14, v); chk("R11", "trap pc saved", v, 32'h0000_0600);
    do_return();
  endtask

  task automatic t_epc_rw();
    logic [31:0] v;
    wr(5'd14, 32'h1234_5678);
    #1; rd(5'd14, v); chk("R12", "epc readback", v, 32'h1234_5678);
    @(negedge clk); eret_req = 1'b1;
    #1; chk("R12", "return uses written epc", redirect_pc, 32'h1234_5678);
    @(negedge clk); eret_req = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    #200000;
    n_checks++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_rw();
    t_cause_readonly();
    t_masked();
    t_disabled();
    t_irq_take();
    t_eret();
    t_exception_slot();
    t_priority();
    t_epc_rw();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule